// File: doc/BRIEF.md
# Pseudo-SRAM Power-Mode Sequencer

This block drives the deep-power-down enable (CE2) of a pseudo-SRAM and tells the access controller when it may start cycles. After reset it holds CE2 high and keeps `ready` low for a fixed wake-up interval. Only after that interval does it open the memory for accesses.

The host may ask for deep power-down with `dpd_req`. The request is taken only while the sequencer is ready and the access controller reports, on `ctrl_idle`, that it is idle with its chip enable deasserted. On entry, CE2 goes low and stays low for at least a minimum hold time. At the same moment `data_lost` is raised, because the array contents do not survive deep power-down. That flag stays set until the host pulses `lost_clr` after rewriting memory.

A later `wake_req` raises CE2 again and starts the same wake-up interval before `ready` returns. Ordinary standby, controlled by the access controller through the chip enable and byte enables, keeps the data and needs no help from this block. Both intervals are derived from the clock-frequency parameter:
- `WAKE_CYC = (CLK_HZ/1000)*WAKE_US/1000`
- `DPD_CYC = ceil((CLK_HZ/1000)*DPD_MIN_NS/1e6)`

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, `ce2` is 1, `ready` is 0 and `data_lost` is 0.
- R2: After reset is released, `ready` stays 0 for the first WAKE_CYC-1 rising edges and becomes 1 at edge WAKE_CYC; `ce2` stays 1 throughout.
- R3: While `ready` is 1, a `dpd_req` sampled with `ctrl_idle` at 0 is ignored: `ce2`, `ready` and `data_lost` keep their values.
- R4: While `ready` is 1, a `dpd_req` sampled with `ctrl_idle` at 1 makes `ce2` 0, `ready` 0 and `data_lost` 1 after that edge.
- R5: Once `ce2` falls, it stays 0 for at least DPD_CYC edges. A `wake_req` sampled in that window is dropped and is not remembered.
- R6: After the hold window, a sampled `wake_req` makes `ce2` 1 at that edge. `ready` then becomes 1 exactly WAKE_CYC edges later.
- R7: During either wake-up interval, `wake_req` and `dpd_req` have no effect: `ce2` stays 1, `ready` stays 0, and the interval length is unchanged.
- R8: A sampled `lost_clr` makes `data_lost` 0 after that edge. If a deep-power-down entry happens on the same edge, `data_lost` is 1.
- R9: `ready` is 1 only while `ce2` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset, applied at power-up |
| dpd_req | input | 1 | Request to enter deep power-down |
| wake_req | input | 1 | Request to leave deep power-down |
| ctrl_idle | input | 1 | Access controller idle with its chip enable deasserted |
| lost_clr | input | 1 | Clears the data-lost flag |
| ce2 | output | 1 | Deep-power-down enable pin; low means powered down |
| ready | output | 1 | Accesses permitted |
| data_lost | output | 1 | Memory contents are invalid since the last deep power-down |

## Verification
The assertions check several rules on every cycle:
- `ready` never appears while CE2 is low.
- CE2 never rises before the low hold time has elapsed.
- `ready` never rises before CE2 has been high for the full wake-up interval.
- CE2 only falls out of the ready state, and together with `data_lost`.
- A busy controller blocks entry.
- A clear takes effect unless an entry wins.

Other behaviour can only be shown by the bench's scenarios:
- The exact edge on which `ready` returns.
- That a dropped wake request is truly forgotten.
- That requests during the wake-up interval do not stretch or shorten it.

A cycle model in the bench compares all three outputs under random request traffic.

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq #(
  parameter int CLK_HZ     = 50_000_000,
  parameter int WAKE_US    = 200,
  parameter int DPD_MIN_NS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dpd_req,
  input  logic wake_req,
  input  logic ctrl_idle,
  input  logic lost_clr,
  output logic ce2,
  output logic ready,
  output logic data_lost
);
  localparam int KHZ      = CLK_HZ / 1000;
  localparam int WAKE_CYC = KHZ * WAKE_US / 1000;
  localparam int DPD_RAW  = (KHZ * DPD_MIN_NS + 999_999) / 1_000_000;
  localparam int DPD_CYC  = (DPD_RAW < 1) ? 1 : DPD_RAW;
  localparam int CW       = $clog2((WAKE_CYC > DPD_CYC) ? WAKE_CYC : DPD_CYC) + 1;

  typedef enum logic [2:0] {
    S_PWRUP, S_ACTIVE, S_HOLD, S_DPD, S_WAKE
  } state_t;

  state_t         st, st_d;
  logic [CW-1:0]  cnt;
  logic           wait_done, hold_done, enter;

  assign wait_done = (cnt == CW'(WAKE_CYC - 1));
  assign hold_done = (cnt == CW'(DPD_CYC - 1));
  assign enter     = (st == S_ACTIVE) && (st_d == S_HOLD);

  always_comb begin
    st_d = st;
    case (st)
      S_PWRUP:  if (wait_done)            st_d = S_ACTIVE;
      S_ACTIVE: if (dpd_req && ctrl_idle) st_d = S_HOLD;
      S_HOLD:   if (hold_done)            st_d = S_DPD;
      S_DPD:    if (wake_req)             st_d = S_WAKE;
      S_WAKE:   if (wait_done)            st_d = S_ACTIVE;
      default:                            st_d = S_PWRUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_PWRUP;
      cnt       <= '0;
      ce2       <= 1'b1;
      ready     <= 1'b0;
      data_lost <= 1'b0;
    end else begin
      st        <= st_d;
      cnt       <= (st_d != st) ? '0 : cnt + 1'b1;
      ce2       <= !(st_d == S_HOLD || st_d == S_DPD);
      ready     <= (st_d == S_ACTIVE);
      data_lost <= enter || (data_lost && !lost_clr);
    end
  end
endmodule

module psram_pwr_seq_chk #(
  parameter int WAKE_CYC = 10000,
  parameter int DPD_CYC  = 50
) (
  input logic clk,
  input logic rst_n,
  input logic dpd_req,
  input logic ctrl_idle,
  input logic lost_clr,
  input logic ce2,
  input logic ready,
  input logic data_lost
);
  localparam int CW = $clog2((WAKE_CYC > DPD_CYC) ? WAKE_CYC : DPD_CYC) + 2;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] lo_cnt, hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ce2 ? '0 : ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ce2 ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  a_r9_ready_needs_ce2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ce2);
  a_r2_wake_blackout: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (hi_cnt >= CW'(WAKE_CYC)));
  a_r5_min_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce2) |-> (lo_cnt >= CW'(DPD_CYC)));
  a_r3_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && dpd_req && !ctrl_idle) |=> ce2);
  a_r4_lost_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_lost) |-> $fell(ce2));
  a_r4_fall_from_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ce2) |-> ($past(ready) && data_lost));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lost_clr |=> (!data_lost || $fell(ce2)));
  a_r7_wait_holds_ce2: assert property (@(posedge clk) disable iff (!rst_n)
    (ce2 && !ready) |=> ce2);
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .WAKE_CYC(WAKE_CYC),
  .DPD_CYC (DPD_CYC)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dpd_req  (dpd_req),
  .ctrl_idle(ctrl_idle),
  .lost_clr (lost_clr),
  .ce2      (ce2),
  .ready    (ready),
  .data_lost(data_lost)
);

// File: tb/psram_pwr_seq_tb.sv
`timescale 1ns/1ps
module psram_pwr_seq_tb;
  localparam int CLK_HZ = 50_000_000;
  localparam int WUS    = 4;
  localparam int DNS    = 400;
  localparam int W      = (CLK_HZ / 1000) * WUS / 1000;
  localparam int D      = ((CLK_HZ / 1000) * DNS + 999_999) / 1_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dpd_req = 1'b0, wake_req = 1'b0, ctrl_idle = 1'b1, lost_clr = 1'b0;
  logic ce2, ready, data_lost;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  psram_pwr_seq #(.CLK_HZ(CLK_HZ), .WAKE_US(WUS), .DPD_MIN_NS(DNS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dpd_req(dpd_req), .wake_req(wake_req),
    .ctrl_idle(ctrl_idle), .lost_clr(lost_clr),
    .ce2(ce2), .ready(ready), .data_lost(data_lost));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  // reference model: 0 power-up wait, 1 ready, 2 low hold, 3 powered down, 4 wake wait
  int m_st = 0, m_cnt = 0;
  bit m_lost = 0;

  function automatic bit exp_ce2(input int s);
    return !(s == 2 || s == 3);
  endfunction

  function automatic bit exp_ready(input int s);
    return s == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_lost = 0;
    end else begin
      int nx;
      nx = m_st;
      case (m_st)
        0: if (m_cnt + 1 == W) nx = 1;
        1: if (dpd_req && ctrl_idle) nx = 2;
        2: if (m_cnt + 1 == D) nx = 3;
        3: if (wake_req) nx = 4;
        4: if (m_cnt + 1 == W) nx = 1;
        default: nx = 0;
      endcase
      if (m_st == 1 && nx == 2) m_lost = 1;
      else if (lost_clr) m_lost = 0;
      m_cnt = (nx != m_st) ? 0 : m_cnt + 1;
      m_st = nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("model ce2", ce2, exp_ce2(m_st));
      chk("model ready", ready, exp_ready(m_st));
      chk("model data_lost", data_lost, m_lost);
    end
  end

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_2468));
    step(3);
    chk("R1 ce2", ce2, 1'b1);
    chk("R1 ready", ready, 1'b0);
    chk("R1 data_lost", data_lost, 1'b0);
    rst_n = 1'b1;
    step(W - 1);
    chk("R2 ready before interval", ready, 1'b0);
    chk("R2 ce2 high", ce2, 1'b1);
    step(1);
    chk("R2 ready at interval", ready, 1'b1);

    ctrl_idle = 1'b0; dpd_req = 1'b1;
    step(2);
    chk("R3 ce2 busy", ce2, 1'b1);
    chk("R3 ready busy", ready, 1'b1);
    chk("R3 data_lost busy", data_lost, 1'b0);

    ctrl_idle = 1'b1;
    step(1);
    dpd_req = 1'b0;
    chk("R4 ce2", ce2, 1'b0);
    chk("R4 ready", ready, 1'b0);
    chk("R4 data_lost", data_lost, 1'b1);

    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    step(D - 1);
    chk("R5 ce2 still low", ce2, 1'b0);
    step(3);
    chk("R5 wake not remembered", ce2, 1'b0);

    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    chk("R6 ce2 raised", ce2, 1'b1);
    chk("R6 ready low", ready, 1'b0);
    wake_req = 1'b1; dpd_req = 1'b1;
    step(3);
    wake_req = 1'b0; dpd_req = 1'b0;
    chk("R7 ce2 during wait", ce2, 1'b1);
    chk("R7 ready during wait", ready, 1'b0);
    step(W - 4);
    chk("R7 interval not shortened", ready, 1'b0);
    step(1);
    chk("R6 ready after interval", ready, 1'b1);
    chk("R9 ce2 with ready", ce2, 1'b1);

    lost_clr = 1'b1;
    step(1);
    lost_clr = 1'b0;
    chk("R8 cleared", data_lost, 1'b0);
    lost_clr = 1'b1; dpd_req = 1'b1;
    step(1);
    lost_clr = 1'b0; dpd_req = 1'b0;
    chk("R8 entry wins", data_lost, 1'b1);
    chk("R4 ce2 second entry", ce2, 1'b0);

    repeat (20000) begin
      dpd_req   = ($urandom % 6) == 0;
      wake_req  = ($urandom % 5) == 0;
      ctrl_idle = ($urandom % 4) != 0;
      lost_clr  = ($urandom % 16) == 0;
      step(1);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule